// File: doc/BRIEF.md
# Fault retry and latch-off controller

This controller sits between a channel's on/off command and the enable of its output stage. It decides, one clock at a time, whether the output may conduct after protection faults. An over-temperature trip or an overload trip while the output is on turns the output off and uses up one restart. After a fault, a restart also needs the externally resolved restart-permitted condition.

The budget has two tiers. An initial allowance of `N_CR` fault switch-offs runs first. After that come timed retry cycles. Each retry cycle begins after a pause of `T_RETRY` clocks and allows `N_NT` further switch-offs. When `N_CYC` retry cycles have been used up, the channel latches off.

The latch clears only when the command is held low without a break for more than `T_DELAY_CR` clocks. That same low interval also reloads the whole budget. A fault flag reports the fault condition when diagnosis is enabled. Sensing, comparators and current-sense generation belong to other blocks.

Top module: `fault_retry_ctrl`

## Requirements
- R1: In a cycle where `out_en` is high and either `ot_trip` or `ol_trip` is high, `out_en` is low in the next cycle.
- R2: `fault_diag` is high from the cycle after a trip until the output turns back on or the budget reloads, but only while `diag_en` is high. When `diag_en` is low, `fault_diag` is low.
- R3: Without a pending fault, `out_en` follows `cmd_in` one cycle late. After a trip, `out_en` rises only in the cycle after one in which `cmd_in` and `restart_ok` are both high, and that rise clears the pending fault.
- R4: The `N_CR`-th trip since the last reload starts a pause. During the pause `out_en` stays low for exactly `T_RETRY` cycles, whatever the inputs are.
- R5: After a pause the channel may run again. Each retry cycle allows `N_NT` trips. The last of these starts another pause.
- R6: The trip that ends the `N_CYC`-th retry cycle sets `latched_off` in the next cycle. While `latched_off` is high, `out_en` stays low regardless of `cmd_in` and `restart_ok`.
- R7: If `cmd_in` is low for `T_DELAY_CR+1` consecutive cycles, then in the next cycle `latched_off` and `fault_diag` are low and the budget is reloaded. This applies in every state, including a pause.
- R8: A single high cycle of `cmd_in` restarts the count of low cycles from zero. So two low runs of `T_DELAY_CR` cycles separated by one high cycle leave `latched_off` high.
- R9: After a reload, the next activation again tolerates `N_CR-1` trips without a pause.
- R10: Both trips high in the same cycle count as one fault and use up one unit of budget.
- R11: After a synchronous reset, `out_en`, `fault_diag` and `latched_off` are low and the budget is at its initial allowance.
- R12: A trip while `out_en` is low uses up no budget and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_in | input | 1 | Channel on command |
| ot_trip | input | 1 | Over-temperature protection trip |
| ol_trip | input | 1 | Overload protection trip |
| restart_ok | input | 1 | Restart-permitted condition |
| diag_en | input | 1 | Diagnosis enable |
| out_en | output | 1 | Output-stage enable |
| fault_diag | output | 1 | Fault indication for diagnosis |
| latched_off | output | 1 | Channel latched off |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that they change only between edges. They also assume that the trips are meaningful only while the output conducts. The bench drives every input at the falling edge. It keeps `cmd_in` sticky, with rare toggles, so that low runs both shorter and longer than the de-latch time occur. It draws trips at a low rate, so that pauses, retry cycles, latch-off and reloads are all reached within the run.

// File: rtl/frc_pkg.sv
package frc_pkg;
   typedef enum logic [1:0] {
      FRC_RUN   = 2'd0,
      FRC_PAUSE = 2'd1,
      FRC_LATCH = 2'd2
   } frc_state_e;

   function automatic int frc_width(input int maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction
endpackage

// File: rtl/frc_tick_timer.sv
module frc_tick_timer #(
   parameter int TERM = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic hit
);
   localparam int CW = frc_pkg::frc_width(TERM);

   if (TERM < 0) begin : g_bad_term
      $error("frc_tick_timer: TERM must not be negative");
   end

   if (TERM == 0) begin : g_direct
      assign hit = run;
   end else begin : g_count
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (rst)
            cnt_q <= '0;
         else if (!run)
            cnt_q <= '0;
         else if (cnt_q != CW'(TERM))
            cnt_q <= cnt_q + 1'b1;
      end

      assign hit = run && (cnt_q == CW'(TERM));

      // R8: a break in the run means no terminal count on the next cycle
      a_r8_break_restarts: assert property (@(posedge clk) disable iff (rst)
         !run |=> !hit);
   end
endmodule

// File: rtl/frc_fsm.sv
module frc_fsm
   import frc_pkg::*;
#(
   parameter int N_CR  = 3,
   parameter int N_NT  = 2,
   parameter int N_CYC = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cmd_in,
   input  logic       trip_any,
   input  logic       restart_ok,
   input  logic       pause_done,
   input  logic       delatch,
   output logic       out_en,
   output logic       faulted,
   output frc_state_e state
);
   localparam int LMAX = (N_CR > N_NT) ? N_CR : N_NT;
   localparam int LW   = frc_width(LMAX);
   localparam int YW   = frc_width(N_CYC);

   if (N_CR < 1) begin : g_bad_ncr
      $error("frc_fsm: N_CR must be at least 1");
   end
   if (N_NT < 1) begin : g_bad_nnt
      $error("frc_fsm: N_NT must be at least 1");
   end
   if (N_CYC < 1) begin : g_bad_ncyc
      $error("frc_fsm: N_CYC must be at least 1");
   end

   frc_state_e     st_q, st_d;
   logic [LW-1:0]  left_q, left_d;
   logic [YW-1:0]  cyc_q, cyc_d;
   logic           retry_q, retry_d;
   logic           flt_q, flt_d;
   logic           out_q, out_d;
   logic           trip;

   assign trip = out_q && trip_any;

   always_comb begin
      st_d    = st_q;
      left_d  = left_q;
      cyc_d   = cyc_q;
      retry_d = retry_q;
      flt_d   = flt_q;
      out_d   = out_q;
      if (delatch) begin
         st_d    = FRC_RUN;
         left_d  = LW'(N_CR);
         cyc_d   = '0;
         retry_d = 1'b0;
         flt_d   = 1'b0;
         out_d   = 1'b0;
      end else begin
         unique case (st_q)
            FRC_RUN: begin
               if (trip) begin
                  out_d = 1'b0;
                  flt_d = 1'b1;
                  if (left_q == LW'(1)) begin
                     if (retry_q && (cyc_q == YW'(N_CYC - 1))) begin
                        st_d = FRC_LATCH;
                     end else begin
                        st_d = FRC_PAUSE;
                        if (retry_q) cyc_d = cyc_q + 1'b1;
                     end
                  end else begin
                     left_d = left_q - 1'b1;
                  end
               end else begin
                  out_d = cmd_in && (out_q || !flt_q || restart_ok);
                  if (out_d && !out_q) flt_d = 1'b0;
               end
            end
            FRC_PAUSE: begin
               out_d = 1'b0;
               if (pause_done) begin
                  st_d    = FRC_RUN;
                  retry_d = 1'b1;
                  left_d  = LW'(N_NT);
               end
            end
            default: begin
               out_d = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= FRC_RUN;
         left_q  <= LW'(N_CR);
         cyc_q   <= '0;
         retry_q <= 1'b0;
         flt_q   <= 1'b0;
         out_q   <= 1'b0;
      end else begin
         st_q    <= st_d;
         left_q  <= left_d;
         cyc_q   <= cyc_d;
         retry_q <= retry_d;
         flt_q   <= flt_d;
         out_q   <= out_d;
      end
   end

   assign out_en  = out_q;
   assign faulted = flt_q;
   assign state   = st_q;

   // R4: no conduction during a pause
   a_r4_pause_dark: assert property (@(posedge clk) disable iff (rst)
      (st_q == FRC_PAUSE) |-> !out_q);
   // R6: latch holds until the de-latch timer fires
   a_r6_latch_sticky: assert property (@(posedge clk) disable iff (rst)
      (st_q == FRC_LATCH && !delatch) |=> (st_q == FRC_LATCH));
   // R10: one trip event (either or both sources) costs exactly one unit
   a_r10_single_charge: assert property (@(posedge clk) disable iff (rst)
      (st_q == FRC_RUN && trip && !delatch && left_q > LW'(1))
      |=> (left_q == $past(left_q) - 1'b1));
   // R12: trips while dark leave the budget alone
   a_r12_dark_trip_free: assert property (@(posedge clk) disable iff (rst)
      (st_q == FRC_RUN && !out_q && !delatch) |=> (left_q == $past(left_q)));
endmodule

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl
   import frc_pkg::*;
#(
   parameter int N_CR       = 3,
   parameter int N_NT       = 2,
   parameter int N_CYC      = 2,
   parameter int T_RETRY    = 16,
   parameter int T_DELAY_CR = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic cmd_in,
   input  logic ot_trip,
   input  logic ol_trip,
   input  logic restart_ok,
   input  logic diag_en,
   output logic out_en,
   output logic fault_diag,
   output logic latched_off
);
   if (T_RETRY < 1) begin : g_bad_tretry
      $error("fault_retry_ctrl: T_RETRY must be at least 1");
   end
   if (T_DELAY_CR < 1) begin : g_bad_tdelay
      $error("fault_retry_ctrl: T_DELAY_CR must be at least 1");
   end

   frc_state_e st;
   logic       pause_done;
   logic       delatch;
   logic       faulted;

   frc_tick_timer #(.TERM(T_RETRY - 1)) u_pause (
      .clk (clk),
      .rst (rst),
      .run (st == FRC_PAUSE),
      .hit (pause_done)
   );

   frc_tick_timer #(.TERM(T_DELAY_CR)) u_delatch (
      .clk (clk),
      .rst (rst),
      .run (!cmd_in),
      .hit (delatch)
   );

   frc_fsm #(.N_CR(N_CR), .N_NT(N_NT), .N_CYC(N_CYC)) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .cmd_in     (cmd_in),
      .trip_any   (ot_trip | ol_trip),
      .restart_ok (restart_ok),
      .pause_done (pause_done),
      .delatch    (delatch),
      .out_en     (out_en),
      .faulted    (faulted),
      .state      (st)
   );

   assign latched_off = (st == FRC_LATCH);
   assign fault_diag  = faulted && diag_en;

   // R1: a trip while conducting switches off on the next cycle
   a_r1_trip_off: assert property (@(posedge clk) disable iff (rst)
      (out_en && (ot_trip || ol_trip)) |=> !out_en);
   // R2: the flag reflects the trip, gated by diagnosis enable
   a_r2_flag_on_trip: assert property (@(posedge clk) disable iff (rst)
      (out_en && (ot_trip || ol_trip)) |=> (fault_diag == diag_en));
   // R3: a rise of the output needs the command, and restart permission after a fault
   a_r3_restart_gate: assert property (@(posedge clk) disable iff (rst)
      $rose(out_en) |-> ($past(cmd_in) && ($past(restart_ok) || !$past(faulted))));
   // R6: latched channel never conducts
   a_r6_latch_dark: assert property (@(posedge clk) disable iff (rst)
      latched_off |-> !out_en);
   // R7: the latch clears only after a low command
   a_r7_clear_on_low: assert property (@(posedge clk) disable iff (rst)
      $fell(latched_off) |-> !$past(cmd_in));
endmodule

// File: tb/sim_fault_retry_ctrl.sv
module sim_fault_retry_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int P_NCR = 3;
   localparam int P_NNT = 2;
   localparam int P_NCY = 2;
   localparam int P_TR  = 5;
   localparam int P_TD  = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cmd_in = 1'b0, ot_trip = 1'b0, ol_trip = 1'b0;
   logic restart_ok = 1'b0, diag_en = 1'b0;
   logic out_en, fault_diag, latched_off;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fault_retry_ctrl #(.N_CR(P_NCR), .N_NT(P_NNT), .N_CYC(P_NCY),
                      .T_RETRY(P_TR), .T_DELAY_CR(P_TD)) u0 (
      .clk(clk), .rst(rst), .cmd_in(cmd_in), .ot_trip(ot_trip), .ol_trip(ol_trip),
      .restart_ok(restart_ok), .diag_en(diag_en),
      .out_en(out_en), .fault_diag(fault_diag), .latched_off(latched_off));

   // reference model written from the requirements: 0 run, 1 pause, 2 latched
   int m_st, m_left, m_cyc, m_pcnt, m_low;
   bit m_retry, m_flt, m_out;

   function automatic bit exp_diag();
      return m_flt && diag_en;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_st = 0; m_left = P_NCR; m_cyc = 0; m_pcnt = 0; m_low = 0;
         m_retry = 0; m_flt = 0; m_out = 0;
      end else begin
         automatic bit tripped = m_out && (ot_trip || ol_trip);
         automatic bit reload  = !cmd_in && (m_low >= P_TD + 1 - 1) && (m_low == P_TD);
         automatic int pc      = m_pcnt;
         m_low  = cmd_in ? 0 : ((m_low < P_TD) ? m_low + 1 : m_low);
         m_pcnt = (m_st == 1) ? pc + 1 : 0;
         if (reload) begin
            m_st = 0; m_left = P_NCR; m_cyc = 0; m_retry = 0; m_flt = 0; m_out = 0;
         end else if (m_st == 0) begin
            if (tripped) begin
               m_out = 0; m_flt = 1;
               if (m_left == 1) begin
                  if (m_retry && m_cyc == P_NCY - 1) m_st = 2;
                  else begin
                     m_st = 1;
                     m_pcnt = 0;
                     if (m_retry) m_cyc++;
                  end
               end else m_left--;
            end else begin
               automatic bit nxt = cmd_in && (m_out || !m_flt || restart_ok);
               if (nxt && !m_out) m_flt = 0;
               m_out = nxt;
            end
         end else if (m_st == 1) begin
            m_out = 0;
            if (pc == P_TR - 1) begin
               m_st = 0; m_retry = 1; m_left = P_NNT;
            end
         end else begin
            m_out = 0;
         end
      end
   end

   task automatic check_bit(input string tag, input logic got, input logic exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%b expected=%b at cycle %0d", tag, got, exp, cycles);
      end
   endtask

   task automatic check_model(input string tag);
      n_tests++;
      if (out_en !== m_out || fault_diag !== exp_diag() || latched_off !== (m_st == 2)) begin
         n_fail++;
         $display("FAIL %s out/diag/latch got=%b%b%b expected=%b%b%b at cycle %0d",
                  tag, out_en, fault_diag, latched_off, m_out, exp_diag(), m_st == 2, cycles);
      end
   endtask

   task automatic tick(input string tag, input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         check_model(tag);
      end
   endtask

   task automatic trip_once(input string tag, input logic ot, input logic ol);
      ot_trip = ot; ol_trip = ol;
      tick(tag);
      ot_trip = 1'b0; ol_trip = 1'b0;
   endtask

   initial begin
      int limit = 100000;
      while (cycles < limit) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check_bit("R11 out_en", out_en, 1'b0);
      check_bit("R11 fault_diag", fault_diag, 1'b0);
      check_bit("R11 latched_off", latched_off, 1'b0);

      // R3 normal follow
      diag_en = 1'b1; restart_ok = 1'b1; cmd_in = 1'b1;
      tick("R3", 2);
      check_bit("R3 follows command", out_en, 1'b1);

      // R1 R2 R10: both trips at once
      trip_once("R10", 1'b1, 1'b1);
      check_bit("R1 switched off", out_en, 1'b0);
      check_bit("R2 flag set", fault_diag, 1'b1);

      // R3 restart gated by restart_ok
      restart_ok = 1'b0;
      tick("R3", 3);
      check_bit("R3 held off", out_en, 1'b0);
      restart_ok = 1'b1;
      tick("R3");
      check_bit("R3 restarted", out_en, 1'b1);
      check_bit("R2 flag cleared", fault_diag, 1'b0);

      // second trip; then third begins pause (R10 counted once earlier)
      trip_once("R1", 1'b0, 1'b1);
      tick("R3", 1);
      check_bit("R10 not yet paused", out_en, 1'b1);
      trip_once("R4", 1'b1, 1'b0);
      for (int i = 0; i < P_TR; i++) begin
         check_bit("R4 pause dark", out_en, 1'b0);
         tick("R4");
      end
      tick("R5");
      check_bit("R5 resumes after pause", out_en, 1'b1);

      // finish retry cycle 1, pause, retry cycle 2, latch
      for (int c = 0; c < P_NCY; c++) begin
         for (int k = 0; k < P_NNT; k++) begin
            trip_once("R5", 1'b0, 1'b1);
            tick("R5", 1);
         end
         tick("R5", P_TR + 1);
      end
      check_bit("R6 latched", latched_off, 1'b1);
      tick("R6", 6);
      check_bit("R6 stays dark", out_en, 1'b0);

      // R8 broken low runs keep the latch
      cmd_in = 1'b0; tick("R8", P_TD);
      cmd_in = 1'b1; tick("R8");
      cmd_in = 1'b0; tick("R8", P_TD);
      check_bit("R8 latch kept", latched_off, 1'b1);
      tick("R7", 2);
      check_bit("R7 latch cleared", latched_off, 1'b0);
      check_bit("R7 flag cleared", fault_diag, 1'b0);

      // R9 full allowance again
      cmd_in = 1'b1; tick("R9", 2);
      for (int k = 0; k < P_NCR - 1; k++) begin
         trip_once("R9", 1'b1, 1'b0);
         tick("R9", 1);
      end
      check_bit("R9 still running", out_en, 1'b1);

      // R2 flag masked by diag_en
      diag_en = 1'b0;
      trip_once("R2", 1'b0, 1'b1);
      check_bit("R2 flag masked", fault_diag, 1'b0);

      // R12 trips while dark, then R7 reload during pause
      cmd_in = 1'b0; tick("R12", 1);
      trip_once("R12", 1'b1, 1'b1);
      tick("R7", P_TD + 2);
      check_bit("R7 reload in pause", latched_off, 1'b0);

      // random phase
      diag_en = 1'b1;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(9) == 0) cmd_in = ~cmd_in;
         restart_ok = ($urandom_range(3) != 0);
         ot_trip = ($urandom_range(11) == 0);
         ol_trip = ($urandom_range(11) == 0);
         if ($urandom_range(63) == 0) diag_en = ~diag_en;
         tick("RND R1 R4 R5 R6 R7 R12");
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule